// File: doc/BRIEF.md
# Stack Push/Pop Bus Sequencer

This block runs the memory bus cycles that move one 16-bit register to or from a stack held in byte-wide memory. A one-cycle `start` pulse together with `pop_sel` launches an operation. Every operation is four machine cycles long, and each machine cycle is three clock cycles (T1, T2, T3). The first two machine cycles read the opcode and a second code byte from a program counter kept inside the block. The last two machine cycles move the two data bytes.

On a push, the stack pointer steps down before each write. The high byte of `push_val` goes out first and the low byte second. On a pop, the low byte is read at the stack pointer and the high byte one address above it. The assembled word appears on `pop_val` alongside a one-cycle `done` pulse. The block drives the address, the write data, the memory request and the read/write strobes, and it samples read data at the end of T3. Instruction decode, wait states and interrupts are handled elsewhere.

Top module: `stack_seq`

## Requirements
- R1: An accepted operation keeps `busy` high for exactly 12 cycles (4 machine cycles x 3 T-states). In the cycle after the final T3, `busy` is low and `done` is high, and `done` is high in no other cycle.
- R2: Machine cycle 0 drives `mem_addr` = PC and machine cycle 1 drives PC+1. PC advances by 2 per operation and starts at parameter `PC_INIT`.
- R3: Push, machine cycle 2: `mem_addr` = SP-1 and `mem_wdata` = `push_val[15:8]`. Push, machine cycle 3: `mem_addr` = SP-2 and `mem_wdata` = `push_val[7:0]`. `mem_wdata` is held for the whole data cycle and is zero in every other cycle.
- R4: Pop, machine cycle 2 reads at SP into `pop_val[7:0]`, and machine cycle 3 reads at SP+1 into `pop_val[15:8]`. `mem_rdata` is sampled on the clock edge that ends T3.
- R5: `mreq` is high in all three T-states of every machine cycle and low when idle. `rd` is high in T2 and T3 of both fetch cycles and of pop data cycles. `wr` is high in T2 and T3 of push data cycles. Both strobes are low in T1.
- R6: On a push, `sp` drops by one at T1 of each data cycle. On a pop, `sp` rises by one at T1 of machine cycle 3 and again in the `done` cycle. The net change is -2 or +2, modulo 2^16 in both directions.
- R7: `start` sampled while `busy` is high is ignored, including on the edge that ends the final T3. `start` in the `done` cycle or later is accepted.
- R8: Synchronous active-high `rst` clears `busy`, `done`, `mreq`, `rd`, `wr`, `mem_wdata` and `pop_val`, loads `sp` with `SP_INIT`, and aborts any operation in progress. The next fetch reads at `PC_INIT`.
- R9: `pop_val` changes only at the two pop data captures and at reset. It holds through pushes and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, honoured only when idle |
| pop_sel | input | 1 | 1 = pop, 0 = push, sampled with `start` |
| push_val | input | 16 | Word to push, sampled with `start` |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Bus address, loaded at T1 |
| mem_wdata | output | 8 | Write data during push data cycles |
| mreq | output | 1 | Memory request, high through every machine cycle |
| rd | output | 1 | Read strobe, T2 and T3 |
| wr | output | 1 | Write strobe, T2 and T3 |
| pop_val | output | 16 | Word assembled by the last pop |
| done | output | 1 | One-cycle pulse after the final T3 |
| busy | output | 1 | Operation in progress |
| sp | output | 16 | Current stack pointer |

## Verification
The hardest case to reach from the ports is a `start` that arrives on the exact edge ending the final T3. At that edge `busy` is still high, so the request must be dropped, and one cycle later an identical request must be taken. The bench gets there by holding `start` high through a run of back-to-back operations, and by injecting single stray pulses at chosen T-states. The bench also steers the stack pointer across 0x0000 in both directions, so that both the pre-decrement and the pop increment wrap. It then resets in the middle of a pop and checks that the half-built word and the pointer steps are discarded.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int MCYC_PER_OP = 4;
  localparam int T_PER_MCYC  = 3;
  localparam int TST_W       = 2;

  typedef enum logic [1:0] {
    MC_OPCODE = 2'd0,
    MC_CODE2  = 2'd1,
    MC_DATA_A = 2'd2,
    MC_DATA_B = 2'd3
  } mcyc_e;
endpackage

// File: rtl/stack_seq_timer.sv
module stack_seq_timer
  import stack_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output logic  busy,
  output mcyc_e mcyc,
  output logic  accept,
  output logic  enter,
  output mcyc_e enter_idx,
  output logic  to_t2,
  output logic  t3_end,
  output logic  finish,
  output logic  done
);
  localparam logic [TST_W-1:0] T_LAST = TST_W'(T_PER_MCYC - 1);
  localparam mcyc_e M_LAST = mcyc_e'(MCYC_PER_OP - 1);

  logic [TST_W-1:0] tst;

  always_comb begin
    accept    = start & ~busy;
    t3_end    = busy & (tst == T_LAST);
    finish    = t3_end & (mcyc == M_LAST);
    enter     = accept | (t3_end & ~finish);
    enter_idx = accept ? MC_OPCODE : mcyc_e'(mcyc + 2'd1);
    to_t2     = busy & (tst == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      mcyc <= MC_OPCODE;
      tst  <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (enter) begin
        busy <= 1'b1;
        mcyc <= enter_idx;
        tst  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        mcyc <= MC_OPCODE;
        tst  <= '0;
      end else if (busy) begin
        tst <= tst + 1'b1;
      end
    end
  end

  // R1: T-states advance one per clock inside a machine cycle
  a_r1_tstate_step: assert property (@(posedge clk) disable iff (rst)
    (busy && tst != T_LAST) |=> (tst == $past(tst) + 2'd1) && (mcyc == $past(mcyc)));
  // R1: done follows the final T3 and the block goes idle
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (rst)
    finish |=> (done && !busy));
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: a start while busy does not restart the sequence
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !t3_end) |=> (busy && mcyc == $past(mcyc)));
endmodule

// File: rtl/stack_seq_ptrs.sv
module stack_seq_ptrs
  import stack_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = '0,
  parameter logic [AW-1:0] PC_INIT = '0
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          enter,
  input  mcyc_e         enter_idx,
  input  logic          is_pop,
  input  logic          finish,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] cyc_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] pc, sp_nxt, pc_nxt;

  always_comb begin
    sp_nxt   = sp;
    pc_nxt   = pc;
    cyc_addr = pc;
    if (enter) begin
      case (enter_idx)
        MC_OPCODE, MC_CODE2: begin
          cyc_addr = pc;
          pc_nxt   = pc + ONE;
        end
        MC_DATA_A: begin
          if (is_pop) begin
            cyc_addr = sp;
          end else begin
            sp_nxt   = sp - ONE;
            cyc_addr = sp_nxt;
          end
        end
        default: begin
          sp_nxt   = is_pop ? (sp + ONE) : (sp - ONE);
          cyc_addr = sp_nxt;
        end
      endcase
    end
    if (finish && is_pop) sp_nxt = sp + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= SP_INIT;
      pc <= PC_INIT;
    end else begin
      sp <= sp_nxt;
      pc <= pc_nxt;
    end
  end

  // R6: the stack pointer only ever moves by one, wrapping modulo 2^AW
  a_r6_sp_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> ((sp == $past(sp) + ONE) || (sp == $past(sp) - ONE)));
  // R2: the program counter only moves forward by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> (pc == $past(pc) + ONE));
endmodule

// File: rtl/stack_seq_bus.sv
module stack_seq_bus
  import stack_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            enter,
  input  mcyc_e           enter_idx,
  input  mcyc_e           mcyc,
  input  logic            cur_pop,
  input  logic            to_t2,
  input  logic            t3_end,
  input  logic            finish,
  input  logic [AW-1:0]   cyc_addr,
  input  logic [2*DW-1:0] cur_val,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mreq,
  output logic            rd,
  output logic            wr,
  output logic [2*DW-1:0] pop_val
);
  logic cyc_wr;
  logic is_data;

  assign is_data = (enter_idx == MC_DATA_A) || (enter_idx == MC_DATA_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mreq      <= 1'b0;
      rd        <= 1'b0;
      wr        <= 1'b0;
      cyc_wr    <= 1'b0;
      pop_val   <= '0;
    end else begin
      if (enter) begin
        mreq     <= 1'b1;
        rd       <= 1'b0;
        wr       <= 1'b0;
        mem_addr <= cyc_addr;
        cyc_wr   <= is_data && !cur_pop;
        if (is_data && !cur_pop)
          mem_wdata <= (enter_idx == MC_DATA_A) ? cur_val[2*DW-1:DW] : cur_val[DW-1:0];
        else
          mem_wdata <= '0;
      end else if (finish) begin
        mreq      <= 1'b0;
        rd        <= 1'b0;
        wr        <= 1'b0;
        cyc_wr    <= 1'b0;
        mem_wdata <= '0;
      end else if (to_t2) begin
        rd <= ~cyc_wr;
        wr <= cyc_wr;
      end
      if (t3_end && cur_pop && !cyc_wr) begin
        if (mcyc == MC_DATA_A) pop_val[DW-1:0]    <= mem_rdata;
        if (mcyc == MC_DATA_B) pop_val[2*DW-1:DW] <= mem_rdata;
      end
    end
  end

  // R5: strobes are exclusive and only inside a memory request
  a_r5_rd_wr_excl: assert property (@(posedge clk) disable iff (rst) !(rd && wr));
  a_r5_strobe_in_mreq: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) |-> mreq);
  // R3: address and write data do not move while the write strobe is up
  a_r3_wdata_held: assert property (@(posedge clk) disable iff (rst)
    wr |-> ($stable(mem_wdata) && $stable(mem_addr)));
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_INIT = '0,
  parameter logic [AW-1:0] PC_INIT = '0
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            pop_sel,
  input  logic [2*DW-1:0] push_val,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mreq,
  output logic            rd,
  output logic            wr,
  output logic [2*DW-1:0] pop_val,
  output logic            done,
  output logic            busy,
  output logic [AW-1:0]   sp
);
  localparam int VW = 2 * DW;

  mcyc_e         mcyc, enter_idx;
  logic          accept, enter, to_t2, t3_end, finish;
  logic          op_q, cur_pop;
  logic [VW-1:0] val_q, cur_val;
  logic [AW-1:0] cyc_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= 1'b0;
      val_q <= '0;
    end else if (accept) begin
      op_q  <= pop_sel;
      val_q <= push_val;
    end
  end

  assign cur_pop = accept ? pop_sel : op_q;
  assign cur_val = accept ? push_val : val_q;

  stack_seq_timer u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .mcyc(mcyc),
    .accept(accept), .enter(enter), .enter_idx(enter_idx), .to_t2(to_t2),
    .t3_end(t3_end), .finish(finish), .done(done)
  );

  stack_seq_ptrs #(.AW(AW), .SP_INIT(SP_INIT), .PC_INIT(PC_INIT)) u_ptrs (
    .clk(clk), .rst(rst), .enter(enter), .enter_idx(enter_idx),
    .is_pop(cur_pop), .finish(finish), .sp(sp), .cyc_addr(cyc_addr)
  );

  stack_seq_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .enter(enter), .enter_idx(enter_idx), .mcyc(mcyc),
    .cur_pop(cur_pop), .to_t2(to_t2), .t3_end(t3_end), .finish(finish),
    .cyc_addr(cyc_addr), .cur_val(cur_val), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mreq(mreq), .rd(rd), .wr(wr),
    .pop_val(pop_val)
  );

  // R8: after reset nothing is requested on the bus
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd && !wr));
endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;
  localparam logic [15:0] SP_I = 16'h0002;
  localparam logic [15:0] PC_I = 16'h0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pop_sel = 1'b0;
  logic [15:0] push_val = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pop_val, sp;
  logic [7:0]  mem_wdata;
  logic        mreq, rd, wr, done, busy;

  always #2 clk = ~clk;

  stack_seq #(.AW(16), .DW(8), .SP_INIT(SP_I), .PC_INIT(PC_I)) uut (
    .clk(clk), .rst(rst), .start(start), .pop_sel(pop_sel), .push_val(push_val),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mreq(mreq), .rd(rd), .wr(wr), .pop_val(pop_val), .done(done),
    .busy(busy), .sp(sp)
  );

  // bench memory driven by the design
  logic [7:0] bmem [256];
  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (wr) bmem[mem_addr[7:0]] <= mem_wdata;

  typedef struct {
    bit mreq, rd, wr, done, busy, in_rst;
    bit [15:0] addr, sp, popv;
    bit [7:0] wdata;
    string areq, preq;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit [7:0]  mmem [256];
  bit [15:0] m_sp, m_pc, m_popv;
  bit        m_first;
  bit        armed = 0;
  int        r7_cnt = 0;
  int        n_chk = 0, n_fail = 0;

  function automatic exp_t idle_e(bit r);
    exp_t e;
    e.mreq = 0; e.rd = 0; e.wr = 0; e.done = 0; e.busy = 0; e.in_rst = r;
    e.addr = 0; e.sp = m_sp; e.popv = m_popv; e.wdata = 0;
    e.areq = "R2"; e.preq = "R9";
    return e;
  endfunction

  task automatic build(bit pop, bit [15:0] val);
    bit [15:0] sp0 = m_sp, pc0 = m_pc, a1, a0, hi_lo;
    bit [7:0]  lo, hi;
    a0 = sp0 + 16'd1;
    lo = mmem[sp0[7:0]];
    hi = mmem[a0[7:0]];
    for (int k = 0; k < 13; k++) begin
      exp_t e;
      int m = k / 3, t = k % 3;
      bit dat = (m >= 2);
      e = idle_e(0);
      if (k < 12) begin
        e.busy = 1; e.mreq = 1;
        e.rd = (t > 0) && (!dat || pop);
        e.wr = (t > 0) && dat && !pop;
        if (m == 0) e.addr = pc0;
        else if (m == 1) e.addr = pc0 + 16'd1;
        else if (pop) e.addr = (m == 2) ? sp0 : sp0 + 16'd1;
        else e.addr = (m == 2) ? sp0 - 16'd1 : sp0 - 16'd2;
        e.areq = (m < 2) ? ((m == 0 && m_first) ? "R8" : "R2") : (pop ? "R4" : "R3");
        e.wdata = (dat && !pop) ? ((m == 2) ? val[15:8] : val[7:0]) : 8'h00;
      end else begin
        e.done = 1;
      end
      if (pop) e.sp = (k >= 12) ? sp0 + 16'd2 : (k >= 9) ? sp0 + 16'd1 : sp0;
      else     e.sp = (k >= 9) ? sp0 - 16'd2 : (k >= 6) ? sp0 - 16'd1 : sp0;
      hi_lo = m_popv;
      if (pop && k >= 9)  hi_lo[7:0]  = lo;
      if (pop && k >= 12) hi_lo[15:8] = hi;
      e.popv = hi_lo;
      e.preq = (pop && k >= 9) ? "R4" : "R9";
      q.push_back(e);
    end
    if (pop) begin
      m_popv = {hi, lo};
      m_sp = sp0 + 16'd2;
    end else begin
      a1 = sp0 - 16'd1; mmem[a1[7:0]] = val[15:8];
      a1 = sp0 - 16'd2; mmem[a1[7:0]] = val[7:0];
      m_sp = sp0 - 16'd2;
    end
    m_pc = pc0 + 16'd2;
    m_first = 0;
  endtask

  // reference model, advanced on every clock
  always @(posedge clk) begin
    armed = 1;
    if (r7_cnt > 0) r7_cnt--;
    if (rst) begin
      q.delete();
      m_sp = SP_I; m_pc = PC_I; m_popv = 0; m_first = 1;
      cur = idle_e(1);
    end else begin
      if (start) begin
        if (q.size() == 0) build(pop_sel, push_val);
        else r7_cnt = 3;
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = idle_e(0);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      string rb, r5, r3, r6;
      rb = cur.in_rst ? "R8" : (r7_cnt > 0 ? "R7" : "R1");
      r5 = cur.in_rst ? "R8" : "R5";
      r3 = cur.in_rst ? "R8" : "R3";
      r6 = cur.in_rst ? "R8" : "R6";
      chk(rb, "busy", 32'(busy), 32'(cur.busy));
      chk(cur.in_rst ? "R8" : "R1", "done", 32'(done), 32'(cur.done));
      chk(r5, "mreq", 32'(mreq), 32'(cur.mreq));
      chk(r5, "rd", 32'(rd), 32'(cur.rd));
      chk(r5, "wr", 32'(wr), 32'(cur.wr));
      chk(r3, "mem_wdata", 32'(mem_wdata), 32'(cur.wdata));
      chk(r6, "sp", 32'(sp), 32'(cur.sp));
      chk(cur.in_rst ? "R8" : cur.preq, "pop_val", 32'(pop_val), 32'(cur.popv));
      if (cur.mreq) chk(cur.areq, "mem_addr", 32'(mem_addr), 32'(cur.addr));
    end
  end

  task automatic run_op(bit pop, bit [15:0] val);
    @(negedge clk); start = 1; pop_sel = pop; push_val = val;
    @(negedge clk); start = 0;
    repeat (13) @(negedge clk);
  endtask

  // op with one stray start pulse s cycles into the sequence
  task automatic run_stray(bit pop, bit [15:0] val, int s);
    @(negedge clk); start = 1; pop_sel = pop; push_val = val;
    @(negedge clk); start = 0;
    repeat (s) @(negedge clk);
    start = 1; pop_sel = ~pop; push_val = ~val;
    @(negedge clk); start = 0; pop_sel = pop;
    repeat (14) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 7 + 3);
      mmem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R3/R6: pushes walking SP down across 0x0000
    run_op(0, 16'hA55A);
    run_op(0, 16'h1234);
    // R4/R6: pops walking back up across 0xFFFF
    run_op(1, 16'h0000);
    run_op(1, 16'hFFFF);
    // R9: pop_val holds through a push
    run_op(0, 16'hBEEF);
    // R7: stray starts in several T-states, including the final T3 edge
    run_stray(1, 16'h0, 2);
    run_stray(0, 16'h5AA5, 7);
    run_stray(1, 16'h0, 11);
    run_stray(1, 16'h0, 12);
    // R7: start held high, back-to-back pushes then pops
    @(negedge clk); start = 1; pop_sel = 0; push_val = 16'hC3D2;
    repeat (40) @(negedge clk);
    pop_sel = 1;
    repeat (40) @(negedge clk);
    start = 0;
    repeat (15) @(negedge clk);
    // R8: reset in the middle of a pop
    @(negedge clk); start = 1; pop_sel = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    run_op(1, 16'h0);
    run_op(0, 16'h7E81);
    run_op(1, 16'h0);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule